// File: doc/BRIEF.md
# Asymmetric Gate Command Deglitch Filter

This block cleans one active-low PWM command pin for a single switch of a half-bridge gate driver. The pin is asynchronous to the logic clock, so it first passes through a two-stage synchroniser. A counter then decides when a new level has persisted long enough to be trusted. The result is an active-high request, `sw_on`, that tells the output stage to turn its switch on.

Two variants come from one parameter. The low-side variant (`CHANNEL` = 0) applies one filter length, `ON_CYC`, to both edges. The high-side variant (`CHANNEL` = 1) uses `ON_CYC` for turn-on. For turn-off it uses a suppression band bounded by `OFF_MIN_CYC` and `OFF_MAX_CYC`:

- An off request shorter than `OFF_MIN_CYC` is dropped.
- A longer off request turns the switch off.
- The off time is then stretched, so that the switch cannot come back on before `OFF_MAX_CYC` edges after the off request began.

All lengths are counted in clock cycles. The defaults are 27, 22 and 40, which suit a 100 MHz clock. Pulses narrower than about 1 µs need not be exact in a real system. Even so, the behaviour below is defined for every width.

Top module: `pwm_cmd_deglitch`

## Requirements
- R1: While `rst` is high, and after it falls until a filter completes, `sw_on` is 0. The synchroniser resets to the idle pin level (high, meaning off).
- R2: If `cmd_n` is held low (on request) for at least `ON_CYC` rising edges, `sw_on` becomes 1. The change is visible after rising edge `ON_CYC`+2, where edge 1 is the first rising edge that samples the new pin level.
- R3: A low pulse on `cmd_n` that covers fewer than `ON_CYC` rising edges leaves `sw_on` at 0 in both variants. `sw_on` never changes while the synchronised request already equals it.
- R4: Low side (`CHANNEL` = 0): a high pulse on `cmd_n` shorter than `ON_CYC` edges is ignored. A high pulse of d ≥ `ON_CYC` edges clears `sw_on` after edge `ON_CYC`+2. `sw_on` is restored after edge d+`ON_CYC`+2.
- R5: High side (`CHANNEL` = 1): a high pulse on `cmd_n` covering fewer than `OFF_MIN_CYC` edges is ignored, and `sw_on` stays 1.
- R6: High side: a high level held for at least `OFF_MIN_CYC` edges clears `sw_on` after edge `OFF_MIN_CYC`+2.
- R7: High side: after an R6 turn-off caused by a high pulse of d edges, `sw_on` returns to 1 after edge max(d+`ON_CYC`, `OFF_MAX_CYC`)+2. The off time therefore never ends before `OFF_MAX_CYC`, and wide pulses see only the normal turn-on filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_n | input | 1 | Asynchronous active-low switch command pin |
| sw_on | output | 1 | Filtered active-high switch-on request |

## Verification
Every result is tied to an edge count from the first rising edge that samples a new pin level.

- A turn-on or a low-side edge appears after edge `ON_CYC`+2.
- A high-side turn-off appears after edge `OFF_MIN_CYC`+2.
- A high-side recovery appears after edge max(d+`ON_CYC`, `OFF_MAX_CYC`)+2.

The bench drives the pin on falling edges and samples `sw_on` on every following falling edge. It compares each sample with a waveform computed from those formulas, sweeping the pulse width across every boundary of a small configuration.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

    // Channel variant: low side filters both edges alike,
    // high side uses the turn-off suppression band.
    typedef enum logic {
        CH_LOW  = 1'b0,
        CH_HIGH = 1'b1
    } chan_e;

    // Depth of the pin synchroniser.
    localparam int unsigned SYNC_STAGES = 2;

    // Decision bundle produced by the edge filter.
    typedef struct packed {
        logic on;      // filtered switch request
        logic commit;  // pulse: a turn-off was accepted this cycle
    } filt_out_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold values 0..n (at least one).
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cmd_sync.sv
module cmd_sync
    import deglitch_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic req_on
);

    logic [STAGES-1:0] chain_q;

    // Reset to the idle (high) pin level so nothing is requested.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_n};
        end
    end

    assign req_on = ~chain_q[STAGES-1];

endmodule

// File: rtl/edge_filter.sv
module edge_filter
    import deglitch_pkg::*;
#(
    parameter chan_e       CHANNEL     = CH_HIGH,
    parameter int unsigned ON_CYC      = 27,
    parameter int unsigned OFF_MIN_CYC = 22
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_on,
    input  logic      hold_ok,
    output filt_out_t fo
);

    // Turn-off length: the variant chooses its own threshold.
    localparam int unsigned OFF_T = (CHANNEL == CH_HIGH) ? OFF_MIN_CYC : ON_CYC;
    localparam int unsigned CW    = cnt_bits(max2(ON_CYC, OFF_T));
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYC - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_T - 1);

    logic          on_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          differ;
    logic          reached;
    logic          may_switch;

    always_comb begin
        last       = on_q ? OFF_LAST : ON_LAST;
        differ     = (req_on != on_q);
        reached    = (cnt_q >= last);
        // Turn-off is never held back; turn-on waits for the off-hold timer.
        may_switch = on_q | hold_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= 1'b0;
            cnt_q <= '0;
        end else if (!differ) begin
            cnt_q <= '0;
        end else if (reached) begin
            if (may_switch) begin
                on_q  <= req_on;
                cnt_q <= '0;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        fo.on     = on_q;
        fo.commit = differ & reached & on_q;
    end

endmodule

// File: rtl/off_hold_timer.sv
module off_hold_timer
    import deglitch_pkg::*;
#(
    parameter int unsigned SPAN = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);

    localparam int unsigned   HW   = cnt_bits(SPAN);
    localparam logic [HW-1:0] LOAD = (SPAN > 0) ? HW'(SPAN - 1) : '0;

    logic [HW-1:0] rem_q;

    // Counts the edges left before a turn-on may complete.
    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (start) begin
            rem_q <= LOAD;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign done = (rem_q == '0);

endmodule

// File: rtl/pwm_cmd_deglitch.sv
module pwm_cmd_deglitch
    import deglitch_pkg::*;
#(
    parameter chan_e       CHANNEL     = CH_HIGH,
    parameter int unsigned ON_CYC      = 27,
    parameter int unsigned OFF_MIN_CYC = 22,
    parameter int unsigned OFF_MAX_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_n,
    output logic sw_on
);

    // Hold span after an accepted turn-off; zero disables it.
    localparam int unsigned HOLD_SPAN =
        (CHANNEL == CH_HIGH && OFF_MAX_CYC > OFF_MIN_CYC) ? (OFF_MAX_CYC - OFF_MIN_CYC) : 0;

    logic      req_on;
    logic      hold_ok;
    filt_out_t fo;

    cmd_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (cmd_n),
        .req_on(req_on)
    );

    edge_filter #(
        .CHANNEL    (CHANNEL),
        .ON_CYC     (ON_CYC),
        .OFF_MIN_CYC(OFF_MIN_CYC)
    ) u_filt (
        .clk    (clk),
        .rst    (rst),
        .req_on (req_on),
        .hold_ok(hold_ok),
        .fo     (fo)
    );

    off_hold_timer #(
        .SPAN(HOLD_SPAN)
    ) u_hold (
        .clk  (clk),
        .rst  (rst),
        .start(fo.commit),
        .done (hold_ok)
    );

    assign sw_on = fo.on;

endmodule

// File: rtl/deglitch_checker.sv
module deglitch_checker
    import deglitch_pkg::*;
#(
    parameter chan_e       CHANNEL     = CH_HIGH,
    parameter int unsigned ON_CYC      = 27,
    parameter int unsigned OFF_MIN_CYC = 22,
    parameter int unsigned OFF_MAX_CYC = 40
) (
    input logic clk,
    input logic rst,
    input logic sw_on,
    input logic req_on,
    input logic hold_ok
);

    localparam int unsigned OFF_T = (CHANNEL == CH_HIGH) ? OFF_MIN_CYC : ON_CYC;
    localparam int unsigned RW    = cnt_bits(max2(max2(ON_CYC, OFF_MAX_CYC), OFF_T) + 1);
    localparam logic [RW-1:0] RMAX = '1;

    // Run length of the synchronised request, including the current edge.
    logic          req_q;
    logic [RW-1:0] run_q;
    logic [RW-1:0] len;

    always_comb begin
        if (req_on == req_q) begin
            len = (run_q == RMAX) ? run_q : run_q + 1'b1;
        end else begin
            len = RW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            run_q <= '0;
        end else begin
            req_q <= req_on;
            run_q <= len;
        end
    end

    // R1: reset forces the request off
    a_r1_reset_off: assert property (@(posedge clk) rst |=> !sw_on);

    // R2: a turn-on follows at least ON_CYC edges of on request
    a_r2_on_after_filter: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_on) |-> ($past(req_on) && ($past(len) >= ON_CYC)));

    // R4 / R6: a turn-off follows at least the variant's off length
    a_r6_off_after_filter: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_on) |-> (!$past(req_on) && ($past(len) >= OFF_T)));

    // R3: no change while the request already matches the output
    a_r3_stable_when_matched: assert property (@(posedge clk) disable iff (rst)
        (req_on == sw_on) |=> $stable(sw_on));

    generate
        if (CHANNEL == CH_HIGH) begin : g_hs_chk
            // R7: turn-on only once the off-hold window is over
            a_r7_hold_respected: assert property (@(posedge clk) disable iff (rst)
                $rose(sw_on) |-> $past(hold_ok));
        end
    endgenerate

endmodule

bind pwm_cmd_deglitch deglitch_checker #(
    .CHANNEL    (CHANNEL),
    .ON_CYC     (ON_CYC),
    .OFF_MIN_CYC(OFF_MIN_CYC),
    .OFF_MAX_CYC(OFF_MAX_CYC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sw_on  (sw_on),
    .req_on (req_on),
    .hold_ok(hold_ok)
);

// File: tb/pwm_cmd_deglitch_tb.sv
module pwm_cmd_deglitch_tb;
    import deglitch_pkg::*;

    timeunit 1ns;
    timeprecision 1ps;

    localparam int H_ON  = 4;
    localparam int H_MIN = 3;
    localparam int H_MAX = 9;
    localparam int L_ON  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_hs = 1'b1;
    logic pin_ls = 1'b1;
    logic out_hs;
    logic out_ls;

    int checks = 0;
    int errors = 0;

    always #2.5ns clk = ~clk;

    pwm_cmd_deglitch #(
        .CHANNEL(CH_HIGH), .ON_CYC(H_ON), .OFF_MIN_CYC(H_MIN), .OFF_MAX_CYC(H_MAX)
    ) u_dut (
        .clk(clk), .rst(rst), .cmd_n(pin_hs), .sw_on(out_hs)
    );

    pwm_cmd_deglitch #(
        .CHANNEL(CH_LOW), .ON_CYC(L_ON), .OFF_MIN_CYC(H_MIN), .OFF_MAX_CYC(H_MAX)
    ) u_dut_ls (
        .clk(clk), .rst(rst), .cmd_n(pin_ls), .sw_on(out_ls)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string ctx);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, ctx, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected output after edge k of a pulse of d edges.
    function automatic logic exp_out(input bit hs, input bit to_on, input int d, input int k);
        if (to_on) begin
            if (hs) return (d >= H_ON) && (k >= H_ON + 2) && (k < d + H_MIN + 2);
            return (d >= L_ON) && (k >= L_ON + 2) && (k < d + L_ON + 2);
        end
        if (hs) return !((d >= H_MIN) && (k >= H_MIN + 2) && (k < imax(d + H_ON, H_MAX) + 2));
        return !((d >= L_ON) && (k >= L_ON + 2) && (k < d + L_ON + 2));
    endfunction

    function automatic string tag_of(input bit hs, input bit to_on, input int d, input int k);
        if (to_on) return (d >= (hs ? H_ON : L_ON)) ? "R2" : "R3";
        if (!hs) return "R4";
        if (d < H_MIN) return "R5";
        return (k < H_MIN + 3) ? "R6" : "R7";
    endfunction

    task automatic drive(input bit hs, input logic v);
        if (hs) pin_hs = v;
        else    pin_ls = v;
    endtask

    task automatic run_case(input bit hs, input bit to_on, input int d);
        logic base;
        logic act;
        base = to_on ? 1'b1 : 1'b0;
        @(negedge clk);
        drive(hs, base);
        repeat (30) @(negedge clk);
        act = hs ? out_hs : out_ls;
        check(act, !to_on, tag_of(hs, to_on, d, 0), $sformatf("hs=%0d on=%0d d=%0d settle", hs, to_on, d));
        drive(hs, ~base);
        for (int k = 1; k <= d + 30; k++) begin
            @(negedge clk);
            act = hs ? out_hs : out_ls;
            check(act, exp_out(hs, to_on, d, k), tag_of(hs, to_on, d, k),
                  $sformatf("hs=%0d on=%0d d=%0d k=%0d", hs, to_on, d, k));
            if (k == d) drive(hs, base);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: in reset, both outputs off even with the low-side pin held low
        pin_hs = 1'b1;
        pin_ls = 1'b0;
        repeat (5) @(negedge clk);
        check(out_hs, 1'b0, "R1", "hs in reset");
        check(out_ls, 1'b0, "R1", "ls in reset with pin low");
        rst = 1'b0;
        // R2: low-side pin low since reset turns on after edge L_ON+2
        for (int k = 1; k <= L_ON + 4; k++) begin
            @(negedge clk);
            check(out_ls, (k >= L_ON + 2), "R2", $sformatf("ls after reset k=%0d", k));
            check(out_hs, 1'b0, "R1", $sformatf("hs idle after reset k=%0d", k));
        end
        pin_ls = 1'b1;
        repeat (30) @(negedge clk);

        for (int d = 1; d <= 10; d++) run_case(1'b0, 1'b1, d);
        for (int d = 1; d <= 10; d++) run_case(1'b0, 1'b0, d);
        for (int d = 1; d <= 8;  d++) run_case(1'b1, 1'b1, d);
        for (int d = 1; d <= 14; d++) run_case(1'b1, 1'b0, d);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule